// File: doc/BRIEF.md
# Dual-Port Host Bridge Register Bank

This block holds the 64-bit control and status registers of a host bridge. Two request ports reach the same storage. The scan port addresses a register by index, where index = byte address >> 3. The memory-mapped port addresses a register by byte offset, and that offset lands on index (offset >> 3) + 0x0A. Each port has its own write permissions.

Several index slots are write aliases rather than storage:
- Two aliases apply AND or OR to the fault register.
- Two aliases set or clear bits of the control register.

A base-address register carries an enable flag in bit 0. The block presents the base address and the enable flag on dedicated outputs, so that decoding logic elsewhere can place the register window. An interrupt status register mirrors an input vector and cannot be written. Any illegal write raises a one-cycle error pulse. When both ports address the same storage register in one cycle, the scan port goes ahead and the memory-mapped request is held off for that cycle.

Top module: `hb_regbank`

## Requirements
- R1: While reset is asserted, every register is cleared to zero, except the base-address register, which loads `base_default | 1`. After reset, `bar_en` is 1, `bar_addr` equals `base_default & BAR_MASK`, and `err_pulse` is 0.
- R2: On the scan port, the following indices are plain 64-bit storage that reads back what was written: 0x00 fault, 0x06 and 0x07 fault action, 0x0F status/error mask, 0x14 DMA upper address.
- R3: A scan write to index 0x01 replaces the fault register with (fault AND data). A scan write to index 0x02 replaces it with (fault OR data).
- R4: A write to index 0x0E loads the control register. A write to index 0x12 ORs the data into it. A write to index 0x13 clears each control bit whose data bit is 1.
- R5: A memory-mapped access at byte offset A reaches index (A >> 3) + 0x0A. For example, offset 0x20 is control and offset 0x50 is the DMA upper address.
- R6: A scan write to index 0x0A stores data AND (BAR_MASK OR 1), where the default BAR_MASK is 0x0003_FFFF_FFF0_0000. `bar_en` is bit 0 of the stored value and `bar_addr` is the stored value ANDed with BAR_MASK. Both outputs hold their value unless such a write occurs.
- R7: A memory-mapped write to the base-address register (offset 0x00) leaves it unchanged and raises `err_pulse`.
- R8: A write to index 0x0B keeps only the data bits under SPB_MASK (default 0x0003_FFFF_0000_0000).
- R9: Index 0x15 reads the `stat_in` value captured on the previous clock edge. A write to index 0x15 from either port changes nothing and raises `err_pulse`.
- R10: A read of an index that is not readable returns all ones. This includes the alias indices 0x01, 0x02, 0x12 and 0x13. A write to an index with no function changes nothing and does not raise `err_pulse`.
- R11: An access whose byte address has bits [2:0] nonzero is not a full 64-bit access. Such a read returns all ones. Such a write changes nothing and raises `err_pulse`.
- R12: Suppose both ports request in the same cycle and their accesses resolve to the same storage register, with aliases counting as their target. Then the scan request proceeds and `mm_gnt` is 0. The held memory-mapped request is granted in the next cycle that has no such clash. Without a clash, `mm_gnt` equals `mm_req`.
- R13: Read data and the `*_rvalid` flag appear one cycle after an accepted read. No valid flag is raised for a write or for a stalled request.
- R14: `err_pulse` is high for exactly the one cycle after each accepted illegal write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_default | input | 64 | Base-address value loaded during reset |
| stat_in | input | 64 | Interrupt status vector, captured every cycle |
| sc_req | input | 1 | Scan port request |
| sc_we | input | 1 | Scan port write enable |
| sc_addr | input | ADDR_W | Scan port byte address (index = addr >> 3) |
| sc_wdata | input | 64 | Scan port write data |
| sc_rdata | output | 64 | Scan port read data |
| sc_rvalid | output | 1 | Scan port read data valid |
| mm_req | input | 1 | Memory-mapped port request, held until granted |
| mm_we | input | 1 | Memory-mapped port write enable |
| mm_addr | input | ADDR_W | Memory-mapped byte offset |
| mm_wdata | input | 64 | Memory-mapped write data |
| mm_gnt | output | 1 | Memory-mapped request accepted this cycle |
| mm_rdata | output | 64 | Memory-mapped read data |
| mm_rvalid | output | 1 | Memory-mapped read data valid |
| bar_addr | output | 64 | Current base address (masked) |
| bar_en | output | 1 | Base-address enable flag |
| err_pulse | output | 1 | One-cycle flag for an illegal write |

## Verification
The bench builds the bank with its default parameters:
- An 8-bit byte address lets the scan port reach every index up to 0x1F. Unused and alias slots can therefore be probed as well as the live ones.
- The memory-mapped port, shifted by ten indices, overlaps the base, control, mask, DMA and status registers. A collision between the two ports is therefore reachable on control, both through a direct write and through a set alias.

The default masks leave bits both above and below the kept field. Writing all ones to the base and service-processor base registers therefore shows the truncation on both sides.

// File: rtl/hb_pkg.sv
package hb_pkg;

    localparam int DW   = 64;
    localparam int NREG = 9;

    // Scan-port indices; the set of aliases and their targets is behaviour.
    localparam int IX_FIR      = 'h00;
    localparam int IX_FIR_AND  = 'h01;
    localparam int IX_FIR_OR   = 'h02;
    localparam int IX_ACT0     = 'h06;
    localparam int IX_ACT1     = 'h07;
    localparam int IX_BAR      = 'h0A;
    localparam int IX_SPB      = 'h0B;
    localparam int IX_CTL      = 'h0E;
    localparam int IX_SEMR     = 'h0F;
    localparam int IX_CTL_SET  = 'h12;
    localparam int IX_CTL_CLR  = 'h13;
    localparam int IX_DMA      = 'h14;
    localparam int IX_STAT     = 'h15;

    typedef enum logic [3:0] {
        T_FIR, T_ACT0, T_ACT1, T_BAR, T_SPB, T_CTL, T_SEMR, T_DMA, T_STAT, T_NONE
    } tgt_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_LOAD, OP_AND, OP_OR, OP_CLR, OP_BAR, OP_SPB
    } op_e;

    typedef struct packed {
        tgt_e tgt;
        op_e  op;
        logic rd_hit;
        logic wr_bad;
    } dec_t;

    function automatic logic [DW-1:0] hb_apply(
        input logic [DW-1:0] cur,
        input op_e           op,
        input logic [DW-1:0] data,
        input logic [DW-1:0] bar_mask,
        input logic [DW-1:0] spb_mask
    );
        logic [DW-1:0] r;
        case (op)
            OP_LOAD: r = data;
            OP_AND:  r = cur & data;
            OP_OR:   r = cur | data;
            OP_CLR:  r = cur & ~data;
            OP_BAR:  r = data & (bar_mask | {{(DW-1){1'b0}}, 1'b1});
            OP_SPB:  r = data & spb_mask;
            default: r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hb_addr_decode.sv
module hb_addr_decode
    import hb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter bit IS_MM       = 1'b0,
    parameter int MM_IDX_BASE = 'h0A
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             misaligned;

    generate
        if (IS_MM) begin : g_mm_map
            assign idx = {1'b0, addr[ADDR_W-1:3]} + IDX_W'(MM_IDX_BASE);
        end else begin : g_scan_map
            assign idx = {1'b0, addr[ADDR_W-1:3]};
        end
    endgenerate

    assign misaligned = |addr[2:0];

    always_comb begin
        dec = '{tgt: T_NONE, op: OP_NONE, rd_hit: 1'b0, wr_bad: 1'b0};
        if (misaligned) begin
            dec.wr_bad = 1'b1;
        end else begin
            case (int'(idx))
                IX_FIR:     dec = '{tgt: T_FIR,  op: OP_LOAD, rd_hit: 1'b1, wr_bad: 1'b0};
                IX_FIR_AND: dec = '{tgt: T_FIR,  op: OP_AND,  rd_hit: 1'b0, wr_bad: 1'b0};
                IX_FIR_OR:  dec = '{tgt: T_FIR,  op: OP_OR,   rd_hit: 1'b0, wr_bad: 1'b0};
                IX_ACT0:    dec = '{tgt: T_ACT0, op: OP_LOAD, rd_hit: 1'b1, wr_bad: 1'b0};
                IX_ACT1:    dec = '{tgt: T_ACT1, op: OP_LOAD, rd_hit: 1'b1, wr_bad: 1'b0};
                IX_BAR: begin
                    dec.tgt    = T_BAR;
                    dec.rd_hit = 1'b1;
                    dec.op     = IS_MM ? OP_NONE : OP_BAR;
                    dec.wr_bad = IS_MM;
                end
                IX_SPB:     dec = '{tgt: T_SPB,  op: OP_SPB,  rd_hit: 1'b1, wr_bad: 1'b0};
                IX_CTL:     dec = '{tgt: T_CTL,  op: OP_LOAD, rd_hit: 1'b1, wr_bad: 1'b0};
                IX_SEMR:    dec = '{tgt: T_SEMR, op: OP_LOAD, rd_hit: 1'b1, wr_bad: 1'b0};
                IX_CTL_SET: dec = '{tgt: T_CTL,  op: OP_OR,   rd_hit: 1'b0, wr_bad: 1'b0};
                IX_CTL_CLR: dec = '{tgt: T_CTL,  op: OP_CLR,  rd_hit: 1'b0, wr_bad: 1'b0};
                IX_DMA:     dec = '{tgt: T_DMA,  op: OP_LOAD, rd_hit: 1'b1, wr_bad: 1'b0};
                IX_STAT:    dec = '{tgt: T_STAT, op: OP_NONE, rd_hit: 1'b1, wr_bad: 1'b1};
                default:    dec = '{tgt: T_NONE, op: OP_NONE, rd_hit: 1'b0, wr_bad: 1'b0};
            endcase
        end
    end

endmodule

// File: rtl/hb_port_arb.sv
module hb_port_arb
    import hb_pkg::*;
(
    input  logic sc_req,
    input  logic mm_req,
    input  tgt_e sc_tgt,
    input  tgt_e mm_tgt,
    output logic sc_go,
    output logic mm_go
);
    logic clash;

    // Aliases decode to their storage target, so a set-alias clashes with control.
    assign clash = sc_req && mm_req && (sc_tgt != T_NONE) && (sc_tgt == mm_tgt);
    assign sc_go = sc_req;
    assign mm_go = mm_req && !clash;

endmodule

// File: rtl/hb_reg_core.sv
module hb_reg_core
    import hb_pkg::*;
#(
    parameter logic [63:0] BAR_MASK = 64'h0003_FFFF_FFF0_0000,
    parameter logic [63:0] SPB_MASK = 64'h0003_FFFF_0000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] base_default,
    input  logic [DW-1:0] stat_in,
    input  logic          sc_go,
    input  logic          sc_we,
    input  dec_t          sc_dec,
    input  logic [DW-1:0] sc_wdata,
    input  logic          mm_go,
    input  logic          mm_we,
    input  dec_t          mm_dec,
    input  logic [DW-1:0] mm_wdata,
    output logic [DW-1:0] sc_rdata,
    output logic          sc_rvalid,
    output logic [DW-1:0] mm_rdata,
    output logic          mm_rvalid,
    output logic [DW-1:0] bar_q,
    output logic          err_pulse
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic [DW-1:0]           sc_rd;
        logic                    sc_rv;
        logic [DW-1:0]           mm_rd;
        logic                    mm_rv;
        logic                    err;
    } st_t;

    st_t st_d, st_q, st_rst;

    function automatic logic [DW-1:0] rd_val(input st_t s, input dec_t d);
        if (d.rd_hit && d.tgt != T_NONE) return s.regs[int'(d.tgt)];
        return '1;
    endfunction

    always_comb begin
        st_rst = '0;
        st_rst.regs[int'(T_BAR)] = base_default | {{(DW-1){1'b0}}, 1'b1};
    end

    always_comb begin
        st_d = st_q;

        st_d.sc_rv = sc_go && !sc_we;
        if (sc_go && !sc_we) st_d.sc_rd = rd_val(st_q, sc_dec);
        st_d.mm_rv = mm_go && !mm_we;
        if (mm_go && !mm_we) st_d.mm_rd = rd_val(st_q, mm_dec);

        if (sc_go && sc_we && sc_dec.tgt != T_NONE && sc_dec.op != OP_NONE)
            st_d.regs[int'(sc_dec.tgt)] = hb_apply(st_q.regs[int'(sc_dec.tgt)],
                                                   sc_dec.op, sc_wdata, BAR_MASK, SPB_MASK);
        if (mm_go && mm_we && mm_dec.tgt != T_NONE && mm_dec.op != OP_NONE)
            st_d.regs[int'(mm_dec.tgt)] = hb_apply(st_d.regs[int'(mm_dec.tgt)],
                                                   mm_dec.op, mm_wdata, BAR_MASK, SPB_MASK);

        st_d.regs[int'(T_STAT)] = stat_in;

        st_d.err = (sc_go && sc_we && sc_dec.wr_bad) || (mm_go && mm_we && mm_dec.wr_bad);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign sc_rdata  = st_q.sc_rd;
    assign sc_rvalid = st_q.sc_rv;
    assign mm_rdata  = st_q.mm_rd;
    assign mm_rvalid = st_q.mm_rv;
    assign bar_q     = st_q.regs[int'(T_BAR)];
    assign err_pulse = st_q.err;

endmodule

// File: rtl/hb_regbank.sv
module hb_regbank
    import hb_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          MM_IDX_BASE = 'h0A,
    parameter logic [63:0] BAR_MASK    = 64'h0003_FFFF_FFF0_0000,
    parameter logic [63:0] SPB_MASK    = 64'h0003_FFFF_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       base_default,
    input  logic [63:0]       stat_in,
    input  logic              sc_req,
    input  logic              sc_we,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic [63:0]       sc_wdata,
    output logic [63:0]       sc_rdata,
    output logic              sc_rvalid,
    input  logic              mm_req,
    input  logic              mm_we,
    input  logic [ADDR_W-1:0] mm_addr,
    input  logic [63:0]       mm_wdata,
    output logic              mm_gnt,
    output logic [63:0]       mm_rdata,
    output logic              mm_rvalid,
    output logic [63:0]       bar_addr,
    output logic              bar_en,
    output logic              err_pulse
);
    dec_t        sc_dec, mm_dec;
    logic        sc_go, mm_go;
    logic [63:0] bar_q;

    hb_addr_decode #(.ADDR_W(ADDR_W), .IS_MM(1'b0), .MM_IDX_BASE(MM_IDX_BASE)) i_sc_dec (
        .addr (sc_addr),
        .dec  (sc_dec)
    );

    hb_addr_decode #(.ADDR_W(ADDR_W), .IS_MM(1'b1), .MM_IDX_BASE(MM_IDX_BASE)) i_mm_dec (
        .addr (mm_addr),
        .dec  (mm_dec)
    );

    hb_port_arb i_arb (
        .sc_req (sc_req),
        .mm_req (mm_req),
        .sc_tgt (sc_dec.tgt),
        .mm_tgt (mm_dec.tgt),
        .sc_go  (sc_go),
        .mm_go  (mm_go)
    );

    hb_reg_core #(.BAR_MASK(BAR_MASK), .SPB_MASK(SPB_MASK)) i_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_default (base_default),
        .stat_in      (stat_in),
        .sc_go        (sc_go),
        .sc_we        (sc_we),
        .sc_dec       (sc_dec),
        .sc_wdata     (sc_wdata),
        .mm_go        (mm_go),
        .mm_we        (mm_we),
        .mm_dec       (mm_dec),
        .mm_wdata     (mm_wdata),
        .sc_rdata     (sc_rdata),
        .sc_rvalid    (sc_rvalid),
        .mm_rdata     (mm_rdata),
        .mm_rvalid    (mm_rvalid),
        .bar_q        (bar_q),
        .err_pulse    (err_pulse)
    );

    assign mm_gnt   = mm_go;
    assign bar_addr = bar_q & BAR_MASK;
    assign bar_en   = bar_q[0];

endmodule

// File: rtl/hb_regbank_chk.sv
module hb_regbank_chk #(
    parameter int ADDR_W      = 8,
    parameter int MM_IDX_BASE = 'h0A
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sc_req,
    input logic              sc_we,
    input logic [ADDR_W-1:0] sc_addr,
    input logic              sc_rvalid,
    input logic              mm_req,
    input logic              mm_we,
    input logic [ADDR_W-1:0] mm_addr,
    input logic              mm_gnt,
    input logic              mm_rvalid,
    input logic [63:0]       bar_addr,
    input logic              bar_en,
    input logic              err_pulse
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] SC_BAR_ADDR = ADDR_W'('h0A << 3);

    logic [IDX_W-1:0] sc_idx, mm_idx;
    logic             plain_hit;

    assign sc_idx = {1'b0, sc_addr[ADDR_W-1:3]};
    assign mm_idx = {1'b0, mm_addr[ADDR_W-1:3]} + IDX_W'(MM_IDX_BASE);
    assign plain_hit = (mm_idx == IDX_W'('h0E)) || (mm_idx == IDX_W'('h0F)) ||
                       (mm_idx == IDX_W'('h14)) || (mm_idx == IDX_W'('h0B));

    // R12
    same_reg_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && mm_req && sc_addr[2:0] == 3'b0 && mm_addr[2:0] == 3'b0 &&
         sc_idx == mm_idx && plain_hit) |-> !mm_gnt);

    // R13
    sc_read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !sc_we) |=> sc_rvalid);

    // R13
    mm_stall_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_req && !mm_gnt) |=> !mm_rvalid);

    // R7
    mm_bar_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_req && mm_gnt && mm_we && mm_addr == '0) |=> err_pulse);

    // R6
    bar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc_req && sc_we && sc_addr == SC_BAR_ADDR) |=> ($stable(bar_en) && $stable(bar_addr)));

    // R11
    misaligned_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && sc_we && sc_addr[2:0] != 3'b0) |=> err_pulse);

endmodule

bind hb_regbank hb_regbank_chk #(.ADDR_W(ADDR_W), .MM_IDX_BASE(MM_IDX_BASE)) i_hb_regbank_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sc_req    (sc_req),
    .sc_we     (sc_we),
    .sc_addr   (sc_addr),
    .sc_rvalid (sc_rvalid),
    .mm_req    (mm_req),
    .mm_we     (mm_we),
    .mm_addr   (mm_addr),
    .mm_gnt    (mm_gnt),
    .mm_rvalid (mm_rvalid),
    .bar_addr  (bar_addr),
    .bar_en    (bar_en),
    .err_pulse (err_pulse)
);

// File: tb/test_hb_regbank.sv
module test_hb_regbank;

    localparam logic [63:0] BASE_DEF = 64'h0001_2345_6780_0000;
    localparam logic [63:0] STAT_VAL = 64'h0000_0012_3400_0000;
    localparam logic [63:0] ONES     = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sc_req = 1'b0, sc_we = 1'b0, mm_req = 1'b0, mm_we = 1'b0;
    logic [7:0]  sc_addr = '0, mm_addr = '0;
    logic [63:0] sc_wdata = '0, mm_wdata = '0;
    logic [63:0] sc_rdata, mm_rdata, bar_addr;
    logic        sc_rvalid, mm_rvalid, mm_gnt, bar_en, err_pulse;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hb_regbank i_hb_regbank (
        .clk(clk), .rst_n(rst_n), .base_default(BASE_DEF), .stat_in(STAT_VAL),
        .sc_req(sc_req), .sc_we(sc_we), .sc_addr(sc_addr), .sc_wdata(sc_wdata),
        .sc_rdata(sc_rdata), .sc_rvalid(sc_rvalid),
        .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
        .mm_gnt(mm_gnt), .mm_rdata(mm_rdata), .mm_rvalid(mm_rvalid),
        .bar_addr(bar_addr), .bar_en(bar_en), .err_pulse(err_pulse)
    );

    typedef struct packed {
        logic        mm;
        logic        we;
        logic [7:0]  addr;
        logic [63:0] data;
        logic [63:0] exp;
        logic        err;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 8'h50, 64'h0, 64'h0001_2345_6780_0001, 1'b0},                 // R1
        '{1'b0, 1'b1, 8'h00, 64'hF0F0_0000_0000_00FF, 64'h0, 1'b0},                 // R2
        '{1'b0, 1'b0, 8'h00, 64'h0, 64'hF0F0_0000_0000_00FF, 1'b0},                 // R2
        '{1'b0, 1'b1, 8'h08, 64'hFF00_0000_0000_000F, 64'h0, 1'b0},                 // R3
        '{1'b0, 1'b1, 8'h10, 64'h0000_0000_0000_0F00, 64'h0, 1'b0},                 // R3
        '{1'b0, 1'b0, 8'h00, 64'h0, 64'hF000_0000_0000_0F0F, 1'b0},                 // R3
        '{1'b0, 1'b1, 8'h30, 64'h1111, 64'h0, 1'b0},                                // R2
        '{1'b0, 1'b0, 8'h30, 64'h0, 64'h1111, 1'b0},                                // R2
        '{1'b0, 1'b1, 8'h70, 64'h8000_0000_0000_0001, 64'h0, 1'b0},                 // R4
        '{1'b0, 1'b1, 8'h90, 64'h4000_0000_0000_0100, 64'h0, 1'b0},                 // R4
        '{1'b0, 1'b1, 8'h98, 64'h8000_0000_0000_0001, 64'h0, 1'b0},                 // R4
        '{1'b1, 1'b0, 8'h20, 64'h0, 64'h4000_0000_0000_0100, 1'b0},                 // R5
        '{1'b1, 1'b1, 8'h50, 64'hABCD, 64'h0, 1'b0},                                // R5
        '{1'b0, 1'b0, 8'hA0, 64'h0, 64'hABCD, 1'b0},                                // R5
        '{1'b0, 1'b1, 8'h50, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 1'b0},                 // R6
        '{1'b0, 1'b0, 8'h50, 64'h0, 64'h0003_FFFF_FFF0_0000, 1'b0},                 // R6
        '{1'b1, 1'b1, 8'h00, 64'h1, 64'h0, 1'b1},                                   // R7
        '{1'b0, 1'b0, 8'h50, 64'h0, 64'h0003_FFFF_FFF0_0000, 1'b0},                 // R7
        '{1'b0, 1'b1, 8'h58, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0},                 // R8
        '{1'b1, 1'b0, 8'h08, 64'h0, 64'h0003_FFFF_0000_0000, 1'b0},                 // R8
        '{1'b0, 1'b1, 8'hA8, 64'h0, 64'h0, 1'b1},                                   // R9
        '{1'b0, 1'b0, 8'hA8, 64'h0, STAT_VAL, 1'b0},                                // R9
        '{1'b0, 1'b0, 8'h18, 64'h0, ONES, 1'b0},                                    // R10
        '{1'b0, 1'b1, 8'h88, 64'h5, 64'h0, 1'b0},                                   // R10
        '{1'b1, 1'b0, 8'h48, 64'h0, ONES, 1'b0},                                    // R10
        '{1'b0, 1'b0, 8'h04, 64'h0, ONES, 1'b0},                                    // R11
        '{1'b0, 1'b1, 8'h01, 64'h0, 64'h0, 1'b1},                                   // R11
        '{1'b0, 1'b0, 8'h00, 64'h0, 64'hF000_0000_0000_0F0F, 1'b0},                 // R11
        '{1'b0, 1'b1, 8'h78, 64'h77, 64'h0, 1'b0},                                  // R2
        '{1'b1, 1'b0, 8'h28, 64'h0, 64'h77, 1'b0},                                  // R5
        '{1'b1, 1'b1, 8'h58, 64'h0, 64'h0, 1'b1}                                    // R9
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Called at a negative edge; returns at the next negative edge.
    task automatic access(input vec_t v, output logic [63:0] rd, output logic rv,
                          output logic er);
        if (v.mm) begin
            mm_req = 1'b1; mm_we = v.we; mm_addr = v.addr; mm_wdata = v.data;
        end else begin
            sc_req = 1'b1; sc_we = v.we; sc_addr = v.addr; sc_wdata = v.data;
        end
        @(negedge clk);
        rd = v.mm ? mm_rdata : sc_rdata;
        rv = v.mm ? mm_rvalid : sc_rvalid;
        er = err_pulse;
        sc_req = 1'b0; mm_req = 1'b0; sc_we = 1'b0; mm_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] rd;
        logic        rv, er;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state at the outputs
        chk("R1 bar_en", {63'b0, bar_en}, 64'h1);
        chk("R1 bar_addr", bar_addr, BASE_DEF & 64'h0003_FFFF_FFF0_0000);
        chk("R1 err_pulse", {63'b0, err_pulse}, 64'h0);
        chk("R1 rvalid", {62'b0, sc_rvalid, mm_rvalid}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            access(VT[i], rd, rv, er);
            if (!VT[i].we) chk($sformatf("row %0d read data", i), rd, VT[i].exp);
            chk($sformatf("row %0d R13 rvalid", i), {63'b0, rv}, {63'b0, !VT[i].we});
            chk($sformatf("row %0d R14 err", i), {63'b0, er}, {63'b0, VT[i].err});
        end

        // R14: pulse lasts one cycle
        @(negedge clk);
        chk("R14 err drops", {63'b0, err_pulse}, 64'h0);

        // R6: outputs after the masked write (bit 0 was zero)
        chk("R6 bar_en cleared", {63'b0, bar_en}, 64'h0);
        chk("R6 bar_addr", bar_addr, 64'h0003_FFFF_FFF0_0000);
        access('{1'b0, 1'b1, 8'h50, 64'h1, 64'h0, 1'b0}, rd, rv, er);
        chk("R6 bar_en set", {63'b0, bar_en}, 64'h1);
        chk("R6 bar_addr zero", bar_addr, 64'h0);

        // R12: same register from both ports
        sc_req = 1'b1; sc_we = 1'b1; sc_addr = 8'h70; sc_wdata = 64'h5;
        mm_req = 1'b1; mm_we = 1'b1; mm_addr = 8'h20; mm_wdata = 64'h9;
        #1 chk("R12 stall on clash", {63'b0, mm_gnt}, 64'h0);
        @(negedge clk);
        sc_req = 1'b0; sc_we = 1'b0;
        #1 chk("R12 grant after clash", {63'b0, mm_gnt}, 64'h1);
        @(negedge clk);
        mm_req = 1'b0; mm_we = 1'b0;
        access('{1'b0, 1'b0, 8'h70, 64'h0, 64'h0, 1'b0}, rd, rv, er);
        chk("R12 stalled write lands last", rd, 64'h9);

        // R12: set-alias clashes with a control read
        sc_req = 1'b1; sc_we = 1'b1; sc_addr = 8'h90; sc_wdata = 64'h10;
        mm_req = 1'b1; mm_we = 1'b0; mm_addr = 8'h20;
        #1 chk("R12 alias clash stall", {63'b0, mm_gnt}, 64'h0);
        @(negedge clk);
        chk("R13 no valid while stalled", {63'b0, mm_rvalid}, 64'h0);
        sc_req = 1'b0; sc_we = 1'b0;
        @(negedge clk);
        mm_req = 1'b0;
        chk("R13 mm read after stall", {63'b0, mm_rvalid}, 64'h1);
        chk("R12 read sees set alias", mm_rdata, 64'h19);

        // R12: different registers proceed together
        sc_req = 1'b1; sc_we = 1'b1; sc_addr = 8'h00; sc_wdata = 64'h3;
        mm_req = 1'b1; mm_we = 1'b0; mm_addr = 8'h20;
        #1 chk("R12 no clash grant", {63'b0, mm_gnt}, 64'h1);
        @(negedge clk);
        sc_req = 1'b0; sc_we = 1'b0; mm_req = 1'b0;
        chk("R12 parallel read", mm_rdata, 64'h19);
        access('{1'b0, 1'b0, 8'h00, 64'h0, 64'h0, 1'b0}, rd, rv, er);
        chk("R2 parallel write", rd, 64'h3);

        finish_run();
    end

endmodule